// File: doc/BRIEF.md
# Eight-Bit ALU with Registered Flags

This block is the arithmetic and logic stage of a small eight-bit processor. Each cycle the sequencer may present one 16-bit instruction word on `instr`, with `issue` high. It also presents the values of the two registers that the instruction names: the register selected by bits [6:4] on `opnd_x`, and the register selected by bits [2:0] on `opnd_y`. Reading the register file and choosing the next instruction are outside this block.

When the word belongs to the ALU class (bits [15:14] = 01), the block computes the result and the new carry, zero and sign flags. It captures all of them in output registers at that clock edge. It also registers a write-back enable and the destination index, so the register file can commit the result on the following cycle. The flags are held inside the block, and the stored carry is the carry input for the next carrying operation.

Bits [13:11] pick the operation. Codes 000 to 110 are binary operations: add with carry, add, subtract with borrow, subtract, AND, OR and XOR. Code 111 opens a unary group whose operation sits in bits [2:1]. Clearing the write-back bit turns a subtract into a compare and an AND into a test: the flags still change but no register is written.

Top module: `alu8_flagunit`

## Requirements
- R1: While `rst` is high at a clock edge, `res`, `wb_dst`, `wb_en`, `flag_c`, `flag_z` and `flag_s` all become 0.
- R2: For a binary operation, bit 7 of `instr` selects the second operand: 1 takes `instr[2:0]` zero-extended, 0 takes `opnd_y`. The first operand is always `opnd_x`.
- R3: Code 000 (add with carry) and code 001 (add) give the low eight bits of `opnd_x + op2 (+ stored carry for 000)`. The new carry is bit 8 of that nine-bit sum.
- R4: Code 010 (subtract with borrow) and code 011 (subtract) give the low eight bits of `opnd_x - op2 (- stored carry for 010)`. The new carry is bit 8 of the nine-bit difference, so it is 1 exactly when a borrow occurs.
- R5: Code 100 (AND), code 101 (OR) and code 110 (XOR) give the bitwise result and clear carry.
- R6: For every ALU operation, zero is 1 exactly when the eight-bit result is 0. Sign equals result bit 7 for every operation except the logical shift.
- R7: In the unary group (code 111), unary code 00 gives the inverse of `opnd_x`, and unary code 01 rotates `opnd_x` right with old bit 0 entering bit 7. Both clear carry.
- R8: Unary code 10 shifts `opnd_x` right with 0 entering bit 7. Carry takes old bit 0 and sign is forced to 0.
- R9: Unary code 11 shifts `opnd_x` right with the stored carry entering bit 7. The new carry takes old bit 0.
- R10: For an issued ALU word, `wb_en` equals `instr[3]` and `wb_dst` equals `instr[10:8]`. The flags update whether `instr[3]` is 0 or 1.
- R11: In a cycle with `issue` low, or with an issued word whose bits [15:14] are not 01, `wb_en` becomes 0. In that cycle `res`, `wb_dst` and all three flags keep their values.
- R12: The result and flags for an issued word appear on the outputs one clock edge after it is presented, and back-to-back issues chain the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction word valid this cycle |
| instr | input | 16 | Instruction word |
| opnd_x | input | 8 | Value of register named by bits [6:4] |
| opnd_y | input | 8 | Value of register named by bits [2:0] |
| res | output | 8 | Registered result |
| wb_en | output | 1 | Registered write-back enable |
| wb_dst | output | 3 | Registered destination register index |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |

## Verification
The bench builds the block with its default data width of 8. At that width the carry out of bit 8 and the sign at bit 7 match the instruction encoding exactly, and every one of the eight immediate values 0 to 7 can be driven. Directed words cover 0x00, 0x7F, 0x80, 0xFF and 0x01 operands, chained carries and compare and test forms. A long random run then mixes all eleven operations with both carry states and both operand sources, and a behavioural model predicts every output on every clock.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int INSTR_W = 16;
  localparam int IDX_W   = 3;

  typedef enum logic [2:0] {
    BOP_ADC   = 3'b000,
    BOP_ADD   = 3'b001,
    BOP_SBC   = 3'b010,
    BOP_SUB   = 3'b011,
    BOP_AND   = 3'b100,
    BOP_OR    = 3'b101,
    BOP_XOR   = 3'b110,
    BOP_UNARY = 3'b111
  } bin_op_e;

  typedef enum logic [1:0] {
    UOP_NOT = 2'b00,
    UOP_ROR = 2'b01,
    UOP_SHR = 2'b10,
    UOP_RCR = 2'b11
  } un_op_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NONE = 2'b11
  } log_op_e;

  typedef struct packed {
    logic             is_alu;
    logic             is_unary;
    logic             is_arith;
    logic             is_sub;
    logic             use_carry;
    log_op_e          lop;
    un_op_e           uop;
    logic             imm_sel;
    logic             write_back;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] imm;
  } alu_ctl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output alu_ctl_t           ctl
);

  bin_op_e bop;
  logic    unused_fields;

  assign bop           = bin_op_e'(instr[13:11]);
  assign unused_fields = ^{instr[6:4], instr[0]};

  always_comb begin
    ctl            = '0;
    ctl.is_alu     = (instr[15:14] == 2'b01);
    ctl.is_unary   = (bop == BOP_UNARY);
    ctl.uop        = un_op_e'(instr[2:1]);
    ctl.imm_sel    = instr[7] & ~ctl.is_unary;
    ctl.write_back = instr[3];
    ctl.dst        = instr[10:8];
    ctl.imm        = instr[2:0];
    ctl.lop        = LOP_NONE;
    case (bop)
      BOP_ADC: begin ctl.is_arith = 1'b1; ctl.use_carry = 1'b1; end
      BOP_ADD: begin ctl.is_arith = 1'b1; end
      BOP_SBC: begin ctl.is_arith = 1'b1; ctl.is_sub = 1'b1; ctl.use_carry = 1'b1; end
      BOP_SUB: begin ctl.is_arith = 1'b1; ctl.is_sub = 1'b1; end
      BOP_AND: ctl.lop = LOP_AND;
      BOP_OR:  ctl.lop = LOP_OR;
      BOP_XOR: ctl.lop = LOP_XOR;
      default: ctl.lop = LOP_NONE;
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int XW = W + 1;

  logic [XW-1:0] ext_a;
  logic [XW-1:0] ext_b;
  logic [XW-1:0] ext_c;
  logic [XW-1:0] total;

  assign ext_a = {1'b0, a};
  assign ext_b = {1'b0, b};
  assign ext_c = {{W{1'b0}}, cin};

  always_comb begin
    if (sub) total = ext_a - ext_b - ext_c;
    else     total = ext_a + ext_b + ext_c;
  end

  assign sum  = total[W-1:0];
  assign cout = total[XW-1];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  log_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      LOP_AND: y = a & b;
      LOP_OR:  y = a | b;
      LOP_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] src,
  input  logic         cin,
  input  un_op_e       op,
  output logic [W-1:0] y,
  output logic         cout,
  output logic         sign_clr
);

  logic fill;

  always_comb begin
    case (op)
      UOP_ROR: fill = src[0];
      UOP_RCR: fill = cin;
      default: fill = 1'b0;
    endcase
  end

  always_comb begin
    if (op == UOP_NOT) y = ~src;
    else               y = {fill, src[W-1:1]};
  end

  assign cout     = (op == UOP_SHR || op == UOP_RCR) ? src[0] : 1'b0;
  assign sign_clr = (op == UOP_SHR);

endmodule

// File: rtl/alu8_flagunit.sv
module alu8_flagunit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic [15:0]  instr,
  input  logic [W-1:0] opnd_x,
  input  logic [W-1:0] opnd_y,
  output logic [W-1:0] res,
  output logic         wb_en,
  output logic [2:0]   wb_dst,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_s
);

  localparam int PAD_W = W - IDX_W;

  alu_ctl_t     ctl;
  logic [W-1:0] op2;
  logic [W-1:0] as_sum;
  logic         as_cout;
  logic [W-1:0] lg_y;
  logic [W-1:0] un_y;
  logic         un_cout;
  logic         un_sclr;
  logic [W-1:0] nxt_res;
  logic         nxt_c;
  logic         nxt_s;
  logic         take;

  alu8_decode u_dec (
    .instr (instr),
    .ctl   (ctl)
  );

  assign op2 = ctl.imm_sel ? {{PAD_W{1'b0}}, ctl.imm} : opnd_y;

  alu8_addsub #(.W(W)) u_as (
    .a    (opnd_x),
    .b    (op2),
    .cin  (flag_c & ctl.use_carry),
    .sub  (ctl.is_sub),
    .sum  (as_sum),
    .cout (as_cout)
  );

  alu8_logic #(.W(W)) u_lg (
    .a  (opnd_x),
    .b  (op2),
    .op (ctl.lop),
    .y  (lg_y)
  );

  alu8_unary #(.W(W)) u_un (
    .src      (opnd_x),
    .cin      (flag_c),
    .op       (ctl.uop),
    .y        (un_y),
    .cout     (un_cout),
    .sign_clr (un_sclr)
  );

  always_comb begin
    if (ctl.is_unary) begin
      nxt_res = un_y;
      nxt_c   = un_cout;
      nxt_s   = un_sclr ? 1'b0 : un_y[W-1];
    end else if (ctl.is_arith) begin
      nxt_res = as_sum;
      nxt_c   = as_cout;
      nxt_s   = as_sum[W-1];
    end else begin
      nxt_res = lg_y;
      nxt_c   = 1'b0;
      nxt_s   = lg_y[W-1];
    end
  end

  assign take = issue & ctl.is_alu;

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      wb_en  <= 1'b0;
      wb_dst <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
      flag_s <= 1'b0;
    end else if (take) begin
      res    <= nxt_res;
      wb_en  <= ctl.write_back;
      wb_dst <= ctl.dst;
      flag_c <= nxt_c;
      flag_z <= (nxt_res == '0);
      flag_s <= nxt_s;
    end else begin
      wb_en  <= 1'b0;
    end
  end

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         issue,
  input logic [15:0]  instr,
  input logic [W-1:0] res,
  input logic         wb_en,
  input logic [2:0]   wb_dst,
  input logic         flag_c,
  input logic         flag_z,
  input logic         flag_s
);

  logic alu_go;
  logic is_logic;
  logic is_shr;

  assign alu_go   = issue && (instr[15:14] == 2'b01);
  assign is_logic = alu_go && (instr[13:12] == 2'b10 || instr[13:11] == 3'b110);
  assign is_shr   = alu_go && (instr[13:11] == 3'b111) && (instr[2:1] == 2'b10);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !alu_go |=> !wb_en && $stable(flag_c) && $stable(flag_z) && $stable(flag_s) && $stable(res)); // R11

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    alu_go |=> flag_z == (res == '0)); // R6

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (alu_go && !is_shr) |=> flag_s == res[W-1]); // R6

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    is_logic |=> !flag_c); // R5

  AST_SHR_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    is_shr |=> !flag_s && !res[W-1]); // R8

  AST_WB_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (rst)
    alu_go |=> wb_en == $past(instr[3]) && wb_dst == $past(instr[10:8])); // R10

endmodule

bind alu8_flagunit alu8_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .issue  (issue),
  .instr  (instr),
  .res    (res),
  .wb_en  (wb_en),
  .wb_dst (wb_dst),
  .flag_c (flag_c),
  .flag_z (flag_z),
  .flag_s (flag_s)
);

// File: tb/sim_alu8_flagunit.sv
module sim_alu8_flagunit;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue;
  logic [15:0] instr;
  logic [7:0]  opnd_x;
  logic [7:0]  opnd_y;
  logic [7:0]  res;
  logic        wb_en;
  logic [2:0]  wb_dst;
  logic        flag_c;
  logic        flag_z;
  logic        flag_s;

  int n_chk  = 0;
  int n_fail = 0;

  int m_res = 0, m_c = 0, m_z = 0, m_s = 0, m_wb = 0, m_dst = 0;

  always #2.5 clk = ~clk;

  alu8_flagunit #(.W(8)) u0 (
    .clk (clk), .rst (rst), .issue (issue), .instr (instr),
    .opnd_x (opnd_x), .opnd_y (opnd_y), .res (res), .wb_en (wb_en),
    .wb_dst (wb_dst), .flag_c (flag_c), .flag_z (flag_z), .flag_s (flag_s)
  );

  function automatic logic [15:0] bin_word(int op, int dst, int imm, int r, int y);
    return {2'b01, 3'(op), 3'(dst), 1'(imm), 3'b000, 1'(r), 3'(y)};
  endfunction

  function automatic logic [15:0] un_word(int uop, int dst, int r);
    return {2'b01, 3'b111, 3'(dst), 1'b0, 3'b000, 1'(r), 2'(uop), 1'b0};
  endfunction

  // behavioural model of one issued word
  task automatic model(input logic iss, input logic [15:0] w, input int x, input int y);
    int op, op2, t, u, r;
    if (!iss || w[15:14] != 2'b01) begin
      m_wb = 0;
      return;
    end
    op  = int'(w[13:11]);
    op2 = w[7] ? int'(w[2:0]) : y;
    r   = 0;
    case (op)
      0: begin t = x + op2 + m_c; r = t & 255; m_c = (t >> 8) & 1; end
      1: begin t = x + op2;       r = t & 255; m_c = (t >> 8) & 1; end
      2: begin t = x - op2 - m_c; r = t & 255; m_c = (t < 0) ? 1 : 0; end
      3: begin t = x - op2;       r = t & 255; m_c = (t < 0) ? 1 : 0; end
      4: begin r = x & op2; m_c = 0; end
      5: begin r = x | op2; m_c = 0; end
      6: begin r = x ^ op2; m_c = 0; end
      default: begin
        u = int'(w[2:1]);
        case (u)
          0: begin r = (~x) & 255; m_c = 0; end
          1: begin r = (x >> 1) | ((x & 1) << 7); m_c = 0; end
          2: begin r = x >> 1; m_c = x & 1; end
          default: begin r = (x >> 1) | (m_c << 7); m_c = x & 1; end
        endcase
      end
    endcase
    m_res = r;
    m_z   = (r == 0) ? 1 : 0;
    m_s   = (op == 7 && w[2:1] == 2'b10) ? 0 : (r >> 7) & 1;
    m_wb  = int'(w[3]);
    m_dst = int'(w[10:8]);
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (int'(res) != m_res || int'(wb_en) != m_wb || int'(wb_dst) != m_dst ||
        int'(flag_c) != m_c || int'(flag_z) != m_z || int'(flag_s) != m_s) begin
      n_fail++;
      $display("FAIL %s: got res=%02h wb=%0d dst=%0d c=%0d z=%0d s=%0d, expected res=%02h wb=%0d dst=%0d c=%0d z=%0d s=%0d",
               tag, res, wb_en, wb_dst, flag_c, flag_z, flag_s,
               m_res, m_wb, m_dst, m_c, m_z, m_s);
    end
  endtask

  // drive away from the edge, let one edge capture, sample 1 ns later
  task automatic apply(input logic iss, input logic [15:0] w, input int x, input int y, input string tag);
    issue  = iss;
    instr  = w;
    opnd_x = 8'(x);
    opnd_y = 8'(y);
    @(posedge clk);
    model(iss, w, x, y);
    #1;
    compare(tag);
  endtask

  function automatic int edge_val(int k);
    case (k % 6)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      3: return 8'h7F;
      4: return 8'h01;
      default: return int'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; issue = 1'b0; instr = '0; opnd_x = '0; opnd_y = '0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset state");
    rst = 1'b0;

    // R3: add and add-with-carry, carry chaining (R12)
    apply(1, bin_word(1, 2, 0, 1, 0), 8'hFF, 8'h01, "R3 add wraps to 0");
    apply(1, bin_word(0, 3, 0, 1, 0), 8'h00, 8'h00, "R3 adc carry in R12");
    apply(1, bin_word(1, 1, 0, 1, 0), 8'h7F, 8'h01, "R3 add to 0x80");
    // R2: immediate vs register operand
    apply(1, bin_word(1, 4, 1, 1, 7), 8'h10, 8'hAA, "R2 imm seven");
    apply(1, bin_word(1, 4, 0, 1, 7), 8'h10, 8'hAA, "R2 reg operand");
    apply(1, bin_word(1, 5, 1, 1, 0), 8'h00, 8'hFF, "R2 imm zero");
    // R4: subtract / borrow
    apply(1, bin_word(3, 0, 0, 1, 0), 8'h00, 8'h01, "R4 sub borrow");
    apply(1, bin_word(2, 0, 0, 1, 0), 8'h05, 8'h05, "R4 sbc borrow in");
    apply(1, bin_word(3, 0, 0, 0, 0), 8'h80, 8'h80, "R4 compare equal R10");
    // R5: logic ops clear carry
    apply(1, bin_word(3, 0, 0, 1, 0), 8'h00, 8'h01, "R4 set carry");
    apply(1, bin_word(4, 6, 0, 0, 0), 8'hF0, 8'h0F, "R5 test zero R10");
    apply(1, bin_word(5, 6, 0, 1, 0), 8'h80, 8'h01, "R5 or sign");
    apply(1, bin_word(6, 6, 0, 1, 0), 8'hFF, 8'hFF, "R5 xor zero R6");
    // unary group
    apply(1, un_word(0, 7, 1), 8'hFF, 0, "R7 not to zero");
    apply(1, un_word(1, 7, 1), 8'h01, 0, "R7 ror bit0 to bit7");
    apply(1, un_word(2, 7, 1), 8'hFF, 0, "R8 shr sign cleared");
    apply(1, un_word(3, 7, 1), 8'h00, 0, "R9 rcr carry in");
    apply(1, un_word(3, 7, 1), 8'h02, 0, "R9 rcr carry out 0");
    // R11: idle and foreign words hold state
    apply(1, bin_word(3, 1, 0, 1, 0), 8'h00, 8'h01, "R4 set carry again");
    apply(0, bin_word(4, 2, 0, 1, 0), 8'h00, 8'h00, "R11 no issue");
    apply(1, 16'h2F35, 8'h00, 8'h00, "R11 non-ALU word");
    apply(1, 16'hC7A5, 8'h00, 8'h00, "R11 jump-class word");

    // long random mix
    for (int i = 0; i < 3000; i++) begin
      int op, x, y;
      logic [15:0] w;
      op = int'($urandom_range(0, 10));
      x  = edge_val(int'($urandom_range(0, 11)));
      y  = edge_val(int'($urandom_range(0, 11)));
      if (op < 7)
        w = bin_word(op, int'($urandom_range(0, 7)), int'($urandom_range(0, 1)),
                     int'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
      else
        w = un_word(op - 7, int'($urandom_range(0, 7)), int'($urandom_range(0, 1)));
      apply(($urandom_range(0, 9) != 0), w, x, y, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 random");
    end

    rst = 1'b1;
    m_res = 0; m_c = 0; m_z = 0; m_s = 0; m_wb = 0; m_dst = 0;
    @(posedge clk);
    #1;
    compare("R1 reset after traffic");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule